// File: doc/BRIEF.md
# Command-Block Status Posting Unit

This unit completes host commands by writing a status word back into a command block held in word-addressed memory. A control request carries the base address of the command block and a control word. The unit forwards the control word to the interface hardware, clears the pending control wakeup, and then posts completion. Input and output events reuse the stored base address and post their own status codes.

Each post is two memory transactions. The first writes the status word to the event's post slot. The second reads the interrupt mask stored in the word directly after that slot and ORs it into a pending-interrupt register. The unit owns the memory port for both transactions and handles one request at a time. Requests arrive over ready/valid handshakes, and a control request is served first when both are offered together.

Top module: `cmd_post_unit`

## Requirements
- R1: After reset, `irq_pend` is zero, `mem_req` is low and `ctl_ready` is high.
- R2: A control handshake latches `ctl_base`. In the next cycle `iface_ctl_valid` and `wake_clr` each pulse high for one cycle, `iface_ctl_word` holds the accepted word, and the status write starts.
- R3: `out_ptr_clr` pulses together with `iface_ctl_valid` exactly when the accepted control word equals 1 (master reset).
- R4: A control post writes to base + 6 a value equal to the code for normal completion (0x1FF) ANDed with `hw_status`.
- R5: An event with `ev_sel`=0 (input) posts to base + 8. An event with `ev_sel`=1 (output) posts to base + 10. Both use the base from the most recent control request.
- R6: Event status codes are 0 → 0x1FF (done), 1 → 0x2FF (input overflow), 2 → 0x3FF (zero-length input block) and 3 → 0x1FF. Each code is ANDed with `hw_status` before it is written.
- R7: After the status write, the unit reads the word at post address + 1 and ORs it into `irq_pend`. Bits that were already pending are kept.
- R8: Only one post runs at a time. While a post is in progress, both ready outputs are low. When both requests are valid in the idle state, the control request is accepted first and the event is accepted after that post finishes.
- R9: `irq_ack` clears the bits it names in `irq_pend`. When a mask merge happens in the same cycle, the merged bits are set.
- R10: While `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Control request valid |
| ctl_ready | output | 1 | Control request accepted when high with valid |
| ctl_base | input | AW | Command-block base address |
| ctl_word | input | DW | Control word |
| ev_valid | input | 1 | Event post request valid |
| ev_ready | output | 1 | Event request accepted when high with valid |
| ev_sel | input | 1 | 0 = input event, 1 = output event |
| ev_code | input | 2 | Status code selector |
| hw_status | input | DW | Live hardware status bits |
| iface_ctl_valid | output | 1 | One-cycle strobe for the control word |
| iface_ctl_word | output | DW | Control word to interface hardware |
| wake_clr | output | 1 | Clears the pending control wakeup |
| out_ptr_clr | output | 1 | Clears the output-in-progress pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory ready; completes the request |
| irq_ack | input | DW | Bits to clear in the pending register |
| irq_pend | output | DW | Pending-interrupt register |

## Verification
The bench offers a control request and an event in the same cycle. A design that ignores the control priority, or lets a second post in while the first is running, puts the writes in the wrong order in the memory log. The bench stretches memory latency to several cycles, which catches a design that advances on the request alone instead of waiting for the ack. The bench acknowledges interrupt bits in the same cycle as a merge; a design that lets the clear win loses the new interrupt. The bench also sends each status code under a partial `hw_status` mask, and checks that a master reset clears the output pointer while an ordinary control word leaves it alone.

// File: rtl/cmd_post_unit.sv
module cmd_post_unit #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_valid,
  output logic          ctl_ready,
  input  logic [AW-1:0] ctl_base,
  input  logic [DW-1:0] ctl_word,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic          ev_sel,
  input  logic [1:0]    ev_code,
  input  logic [DW-1:0] hw_status,
  output logic          iface_ctl_valid,
  output logic [DW-1:0] iface_ctl_word,
  output logic          wake_clr,
  output logic          out_ptr_clr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] irq_ack,
  output logic [DW-1:0] irq_pend
);
  localparam logic [3:0] CTL_OFF = 4'd6;
  localparam logic [3:0] IN_OFF  = 4'd8;
  localparam logic [3:0] OUT_OFF = 4'd10;
  localparam logic [DW-1:0] ST_DONE = DW'(10'o777);
  localparam logic [DW-1:0] ST_OVF  = DW'(10'o1377);
  localparam logic [DW-1:0] ST_ZERO = DW'(10'o1777);

  typedef enum logic [1:0] {IDLE, WPOST, RMASK} st_t;

  st_t           st;
  logic [AW-1:0] base_q;
  logic [3:0]    off_q;
  logic [DW-1:0] code_q;
  logic [AW-1:0] post_addr;
  logic          ctl_fire, ev_fire, merge;

  function automatic logic [DW-1:0] code_of(input logic [1:0] c);
    case (c)
      2'd1:    return ST_OVF;
      2'd2:    return ST_ZERO;
      default: return ST_DONE;
    endcase
  endfunction

  assign ctl_ready = (st == IDLE);
  assign ev_ready  = (st == IDLE) && !ctl_valid;
  assign ctl_fire  = ctl_valid && ctl_ready;
  assign ev_fire   = ev_valid && ev_ready;

  assign post_addr = base_q + AW'(off_q);
  assign mem_req   = (st != IDLE);
  assign mem_we    = (st == WPOST);
  assign mem_addr  = (st == RMASK) ? post_addr + AW'(1) : post_addr;
  assign mem_wdata = (st == WPOST) ? (code_q & hw_status) : '0;
  assign merge     = (st == RMASK) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st              <= IDLE;
      base_q          <= '0;
      off_q           <= '0;
      code_q          <= '0;
      iface_ctl_valid <= 1'b0;
      iface_ctl_word  <= '0;
      wake_clr        <= 1'b0;
      out_ptr_clr     <= 1'b0;
      irq_pend        <= '0;
    end else begin
      iface_ctl_valid <= 1'b0;
      wake_clr        <= 1'b0;
      out_ptr_clr     <= 1'b0;
      irq_pend        <= (irq_pend & ~irq_ack) | (merge ? mem_rdata : '0);
      case (st)
        IDLE: begin
          if (ctl_fire) begin
            base_q          <= ctl_base;
            off_q           <= CTL_OFF;
            code_q          <= ST_DONE;
            iface_ctl_valid <= 1'b1;
            iface_ctl_word  <= ctl_word;
            wake_clr        <= 1'b1;
            out_ptr_clr     <= (ctl_word == DW'(1));
            st              <= WPOST;
          end else if (ev_fire) begin
            off_q  <= ev_sel ? OUT_OFF : IN_OFF;
            code_q <= code_of(ev_code);
            st     <= WPOST;
          end
        end
        WPOST: if (mem_ack) st <= RMASK;
        RMASK: if (mem_ack) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_post_unit_chk.sv
module cmd_post_unit_chk #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_valid,
  input logic          ctl_ready,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic          iface_ctl_valid,
  input logic [DW-1:0] iface_ctl_word,
  input logic          out_ptr_clr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic          mem_ack,
  input logic [DW-1:0] irq_pend
);
  // R1
  always @(posedge clk) if (rst_n && $past(!rst_n)) reset_idle_chk: assert (!mem_req && ctl_ready && irq_pend == '0);

  // R2
  ctl_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid && ctl_ready |=> iface_ctl_valid && mem_req && mem_we);

  // R2
  strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iface_ctl_valid |=> !iface_ctl_valid);

  // R3
  mrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ptr_clr |-> iface_ctl_valid && iface_ctl_word == DW'(1));

  // R7
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> (irq_pend & $past(mem_rdata)) == $past(mem_rdata));

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_valid && ctl_ready && ev_valid && ev_ready));

  // R8
  ev_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> mem_req && mem_we && !iface_ctl_valid);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));
endmodule

bind cmd_post_unit cmd_post_unit_chk #(.DW(DW), .AW(AW)) chk_i (.*);

// File: tb/cmd_post_unit_tb_top.sv
`timescale 1ns/1ps
module cmd_post_unit_tb_top;
  localparam int DW = 16;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_valid = 0, ev_valid = 0, ev_sel = 0;
  logic ctl_ready, ev_ready;
  logic [AW-1:0] ctl_base = '0;
  logic [DW-1:0] ctl_word = '0, hw_status = 16'hFFFF, irq_ack = '0;
  logic [1:0] ev_code = '0;
  logic iface_ctl_valid, wake_clr, out_ptr_clr;
  logic [DW-1:0] iface_ctl_word, mem_wdata, mem_rdata, irq_pend;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0, lat = 0, wait_cnt = 0, wn = 0, cyc = 0;
  logic [DW-1:0] mem [0:1023];
  logic [AW-1:0] wlog [0:63];
  logic [AW-1:0] last_raddr;

  always #4 clk = ~clk;

  cmd_post_unit #(.DW(DW), .AW(AW)) dut_i (.*);

  assign mem_ack   = mem_req && (wait_cnt == lat);
  assign mem_rdata = mem_ack && !mem_we ? mem[mem_addr[9:0]] : '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ack) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (mem_req && mem_ack && mem_we) begin
      mem[mem_addr[9:0]] <= mem_wdata;
      wlog[wn[5:0]] <= mem_addr;
      wn <= wn + 1;
    end
    if (mem_req && mem_ack && !mem_we) last_raddr <= mem_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (mem_req || !ctl_ready);
  endtask

  task automatic do_ctl(input logic [AW-1:0] b, input logic [DW-1:0] w, input logic exp_clr);
    @(negedge clk);
    ctl_valid = 1; ctl_base = b; ctl_word = w;
    @(negedge clk);
    ctl_valid = 0;
    chk("R2 strobe", iface_ctl_valid, 1);
    chk("R2 wake_clr", wake_clr, 1);
    chk("R2 word", iface_ctl_word, w);
    chk("R3 out_ptr_clr", out_ptr_clr, exp_clr);
    @(negedge clk);
    chk("R2 single pulse", iface_ctl_valid, 0);
    wait_idle();
  endtask

  task automatic do_ev(input logic s, input logic [1:0] c);
    @(negedge clk);
    ev_valid = 1; ev_sel = s; ev_code = c;
    @(negedge clk);
    ev_valid = 0;
    chk("R8 busy ready", {ctl_ready, ev_ready}, 0);
    wait_idle();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq_pend", irq_pend, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 ctl_ready", ctl_ready, 1);
  endtask

  task automatic t_control();
    mem[10'h107] = 16'h0005;
    hw_status = 16'hFFFF;
    do_ctl(16'h0100, 16'h0042, 0);
    chk("R4 post value", mem[10'h106], 16'h01FF);
    chk("R7 mask addr", last_raddr, 16'h0107);
    chk("R7 irq merge", irq_pend, 16'h0005);
  endtask

  task automatic t_master_reset();
    mem[10'h207] = 16'h0030;
    hw_status = 16'h00F0;
    do_ctl(16'h0200, 16'h0001, 1);
    chk("R4 and status", mem[10'h206], 16'h00F0);
    chk("R7 keep old bits", irq_pend, 16'h0035);
    hw_status = 16'hFFFF;
  endtask

  task automatic t_events();
    mem[10'h209] = 16'h0100;
    mem[10'h20B] = 16'h8000;
    do_ev(0, 2'd1);
    chk("R5 R6 input overflow", mem[10'h208], 16'h02FF);
    chk("R7 input mask", irq_pend, 16'h0135);
    do_ev(1, 2'd0);
    chk("R5 R6 output done", mem[10'h20A], 16'h01FF);
    chk("R7 output mask", irq_pend, 16'h8135);
    hw_status = 16'h0F0F;
    do_ev(0, 2'd2);
    chk("R6 zero length", mem[10'h208], 16'h030F);
    do_ev(0, 2'd3);
    chk("R6 code 3", mem[10'h208], 16'h010F);
    hw_status = 16'hFFFF;
  endtask

  task automatic t_wait();
    int n0;
    lat = 3;
    mem[10'h20B] = 16'h0200;
    n0 = wn;
    @(negedge clk);
    ev_valid = 1; ev_sel = 1; ev_code = 2'd1;
    @(negedge clk);
    ev_valid = 0;
    repeat (2) @(negedge clk);
    chk("R10 no early write", wn - n0, 0);
    chk("R10 held addr", mem_addr, 16'h020A);
    wait_idle();
    chk("R10 one write", wn - n0, 1);
    chk("R10 slow post", mem[10'h20A], 16'h02FF);
    chk("R10 slow merge", irq_pend, 16'h8335);
    lat = 0;
  endtask

  task automatic t_priority();
    int n0;
    mem[10'h307] = 16'h0000;
    mem[10'h309] = 16'h0000;
    n0 = wn;
    @(negedge clk);
    ctl_valid = 1; ctl_base = 16'h0300; ctl_word = 16'h0007;
    ev_valid = 1; ev_sel = 0; ev_code = 2'd0;
    @(negedge clk);
    ctl_valid = 0;
    chk("R8 control first", iface_ctl_valid, 1);
    while (!ev_ready) begin
      if (mem_req) chk("R8 no grant while busy", ev_ready, 0);
      @(negedge clk);
    end
    @(negedge clk);
    ev_valid = 0;
    wait_idle();
    chk("R8 two writes", wn - n0, 2);
    chk("R8 order first", wlog[n0[5:0]], 16'h0306);
    chk("R8 order second", wlog[n0[5:0] + 6'd1], 16'h0308);
  endtask

  task automatic t_ack();
    @(negedge clk);
    irq_ack = 16'h0005;
    @(negedge clk);
    irq_ack = '0;
    chk("R9 clear bits", irq_pend, 16'h8330);
    mem[10'h309] = 16'h0040;
    @(negedge clk);
    ev_valid = 1; ev_sel = 0; ev_code = 2'd0;
    @(negedge clk);
    ev_valid = 0;
    while (mem_req) begin
      irq_ack = (!mem_we && mem_ack) ? 16'h0040 : 16'h0000;
      @(negedge clk);
    end
    irq_ack = '0;
    chk("R9 merge wins", irq_pend, 16'h8370);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    t_reset();
    t_control();
    t_master_reset();
    t_events();
    t_wait();
    t_priority();
    t_ack();
    finish_run();
  end

  initial begin
    wait (cyc > 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    finish_run();
  end
endmodule